// File: doc/BRIEF.md
# MDIO Read Master with Turnaround Error Detection

This block is the management-side master for reads from an external PHY register over the two-wire MDIO/MDC management link. A command carries a 5-bit PHY address and a 5-bit register address. The block produces MDC from the system clock. It shifts the read frame out on the MDIO output and then releases the line. It shifts the 16 register bits back in and returns them with a one-cycle completion strobe.

The PHY must pull MDIO low in the second turnaround bit of a read. The block samples the line at that bit. A high level there means the PHY and the master have lost step. In that case the returned data is marked invalid, and the read should be issued again.

A sticky read-error status bit records that event. A host write of 1 clears it. An enable bit gates it onto the interrupt output. Both bits are cleared only by the hard reset, `rst_n`.

The command port is valid/ready. `cmd_ready` is high only while the block is idle. A command held on `cmd_valid` while the block is busy waits and is taken when the frame ends. The response side cannot push back. `rsp_valid` is a single-cycle strobe, and the consumer must take `rsp_data` and `rsp_err` in that cycle.

Top module: `mdio_rd_master`

## Requirements
- R1: After a command is accepted, the block drives 46 bits on `mdio_o` with `mdio_oe` high, MSB first. These are 32 ones, then 0,1 (start), then 1,0 (read code), then the 5-bit PHY address, then the 5-bit register address.
- R2: For the remaining 18 bits of the frame (two turnaround bits and 16 data bits), `mdio_oe` is low.
- R3: `mdc` is low while idle. While busy it toggles every `DIV_HALF` system clocks, and its first rise comes `DIV_HALF` clocks after acceptance. `mdio_o` and `mdio_oe` change only while `mdc` is low, that is, on its falling edges or at acceptance.
- R4: The block samples the 16 data bits on the MDC rises that follow the turnaround. It returns them MSB first on `rsp_data`.
- R5: `rsp_valid` pulses for exactly one cycle, `128*DIV_HALF` clocks after the accepting edge. It does so for every frame, including frames with a turnaround error.
- R6: If MDIO is high at the second turnaround rise, `rsp_err` is 1 with the strobe and `rd_err` becomes 1 in the same cycle. If it is low, `rsp_err` is 0 and `rd_err` keeps its value.
- R7: `irq` is high exactly when both `rd_err` and `rd_err_en` are 1.
- R8: On a host write (`host_we`), `host_wdata[0]`=1 clears `rd_err` and 0 leaves it unchanged. A set in the same cycle wins over the clear. `host_wdata[1]` is written into `rd_err_en`.
- R9: `cmd_ready` is high only while idle. A command is taken on `cmd_valid && cmd_ready`.
- R10: After reset, `rd_err`, `rd_err_en`, `irq`, `rsp_valid`, `mdc` and `mdio_oe` are 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hard reset, active low |
| cmd_valid | input | 1 | Read command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_phy_addr | input | 5 | Target PHY address |
| cmd_reg_addr | input | 5 | Target register address |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_data | output | 16 | Register data read |
| rsp_err | output | 1 | Data invalid, turnaround was not low |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line level |
| host_we | input | 1 | Host write strobe for status/enable |
| host_wdata | input | 2 | Bit 0 clears status on 1, bit 1 is the enable value |
| rd_err | output | 1 | Sticky read-error status |
| rd_err_en | output | 1 | Read-error interrupt enable |
| irq | output | 1 | Interrupt output |

## Verification
The accepting edge is counted as cycle 0. The first MDC rise falls on cycle `DIV_HALF`, and the strobe with data and error on cycle `128*DIV_HALF`. The bench keeps a free-running edge counter, stamps the accepting edge with it, and checks both intervals and the spacing of every rise. It reads MDIO and drives its PHY model at the falling clock edge after each MDC rise, so sampled bits are never racing the design. The status bit and `irq` are compared in the same cycle as the strobe. Host writes are checked one cycle after the write edge, and one clear is timed to land on the very edge that sets the error.

// File: rtl/mdio_rd_pkg.sv
package mdio_rd_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;

  function automatic int hdr_bits(input int pre_len, input int phy_aw, input int reg_aw);
    return pre_len + 4 + phy_aw + reg_aw;
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick      = run && (cnt_q == CNT_TOP);
  assign rise_tick = tick && !mdc;
  assign fall_tick = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_rd_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int PHY_AW  = 5,
  parameter int REG_AW  = 5,
  parameter int DW      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [PHY_AW-1:0] cmd_phy_addr,
  input  logic [REG_AW-1:0] cmd_reg_addr,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              err_set,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data,
  output logic              rsp_err
);
  localparam int HDR   = hdr_bits(PRE_LEN, PHY_AW, REG_AW);
  localparam int FRAME = HDR + 2 + DW;
  localparam int IW    = $clog2(FRAME);
  localparam logic [IW-1:0] TA2_IDX  = IW'(HDR + 1);
  localparam logic [IW-1:0] DAT_IDX  = IW'(HDR + 2);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME - 1);
  localparam logic [IW-1:0] HDR_IDX  = IW'(HDR);

  seq_state_e     state_q;
  logic [IW-1:0]  idx_q;
  logic [HDR-1:0] tx_q;
  logic [DW-1:0]  rx_q;
  logic           ta_bad_q;
  logic           fin;

  assign busy      = (state_q == SEQ_BUSY);
  assign cmd_ready = !busy;
  assign mdio_o    = tx_q[HDR-1];
  assign mdio_oe   = busy && (idx_q < HDR_IDX);
  assign fin       = busy && fall_tick && (idx_q == LAST_IDX);
  assign err_set   = fin && ta_bad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      idx_q     <= '0;
      tx_q      <= '0;
      rx_q      <= '0;
      ta_bad_q  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          state_q  <= SEQ_BUSY;
          idx_q    <= '0;
          tx_q     <= {{PRE_LEN{1'b1}}, 4'b0110, cmd_phy_addr, cmd_reg_addr};
          ta_bad_q <= 1'b0;
        end
      end else begin
        if (rise_tick) begin
          if (idx_q == TA2_IDX) begin
            ta_bad_q <= mdio_i;
          end
          if (idx_q >= DAT_IDX) begin
            rx_q <= {rx_q[DW-2:0], mdio_i};
          end
        end
        if (fall_tick) begin
          if (fin) begin
            state_q   <= SEQ_IDLE;
            rsp_valid <= 1'b1;
            rsp_data  <= rx_q;
            rsp_err   <= ta_bad_q;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
          tx_q <= {tx_q[HDR-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_err_irq.sv
module mdio_err_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       err_set,
  input  logic       host_we,
  input  logic [1:0] host_wdata,
  output logic       rd_err,
  output logic       rd_err_en,
  output logic       irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_err    <= 1'b0;
      rd_err_en <= 1'b0;
    end else begin
      if (err_set) begin
        rd_err <= 1'b1;
      end else if (host_we && host_wdata[0]) begin
        rd_err <= 1'b0;
      end
      if (host_we) begin
        rd_err_en <= host_wdata[1];
      end
    end
  end

  assign irq = rd_err & rd_err_en;
endmodule

// File: rtl/mdio_rd_master.sv
module mdio_rd_master #(
  parameter int DIV_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [4:0]  cmd_phy_addr,
  input  logic [4:0]  cmd_reg_addr,
  output logic        rsp_valid,
  output logic [15:0] rsp_data,
  output logic        rsp_err,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  input  logic        host_we,
  input  logic [1:0]  host_wdata,
  output logic        rd_err,
  output logic        rd_err_en,
  output logic        irq
);
  logic busy;
  logic rise_tick;
  logic fall_tick;
  logic err_set;

  mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_seq #(.PRE_LEN(32), .PHY_AW(5), .REG_AW(5), .DW(16)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_phy_addr (cmd_phy_addr),
    .cmd_reg_addr (cmd_reg_addr),
    .rise_tick    (rise_tick),
    .fall_tick    (fall_tick),
    .mdio_i       (mdio_i),
    .busy         (busy),
    .mdio_o       (mdio_o),
    .mdio_oe      (mdio_oe),
    .err_set      (err_set),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .rsp_err      (rsp_err)
  );

  mdio_err_irq u_err (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_set    (err_set),
    .host_we    (host_we),
    .host_wdata (host_wdata),
    .rd_err     (rd_err),
    .rd_err_en  (rd_err_en),
    .irq        (irq)
  );
endmodule

// File: rtl/mdio_rd_master_chk.sv
module mdio_rd_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        host_we,
  input logic [1:0]  host_wdata,
  input logic        rd_err,
  input logic        rd_err_en,
  input logic        irq
);
  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_mdc_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mdc);

  assert_oe_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_oe) |-> !mdc);

  assert_out_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mdio_o) && mdio_oe) |-> !mdc);

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_err_sets_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> rd_err);

  assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err && rd_err_en) |-> irq);

  assert_w1c_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_wdata[0]) |=> (!rd_err || (rsp_valid && rsp_err)));

  assert_w0_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !host_wdata[0] && rd_err) |=> rd_err);
endmodule

bind mdio_rd_master mdio_rd_master_chk u_chk (.*);

// File: tb/mdio_rd_master_bench.sv
`timescale 1ns/1ps
module mdio_rd_master_bench;
  localparam int H = 2;
  localparam int LAT = 128 * H;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [4:0]  cmd_phy_addr = '0;
  logic [4:0]  cmd_reg_addr = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        rsp_err;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i;
  logic        host_we = 1'b0;
  logic [1:0]  host_wdata = '0;
  logic        rd_err;
  logic        rd_err_en;
  logic        irq;
  logic        phy_drv = 1'b1;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit exp_err = 1'b0;
  bit exp_en = 1'b0;

  assign mdio_i = mdio_oe ? mdio_o : phy_drv;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio_rd_master #(.DIV_HALF(H)) u_mdio_rd_master (.*);

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input bit clr, input bit en);
    @(negedge clk);
    host_we = 1'b1;
    host_wdata = {en, clr};
    @(negedge clk);
    host_we = 1'b0;
    if (clr) exp_err = 1'b0;
    exp_en = en;
  endtask

  task automatic run_frame(input logic [4:0] phy, input logic [4:0] rega,
                           input logic [15:0] dat, input bit ta_val, input bit clr_at_end);
    logic [45:0] hdr_exp;
    logic [45:0] hdr_got;
    logic        oe_bad;
    int          acc;
    int          rise_cyc;
    int          rise_bad;
    int          waited;
    hdr_exp = {32'hFFFF_FFFF, 4'b0110, phy, rega};
    hdr_got = '0;
    oe_bad = 1'b0;
    rise_bad = 0;
    rise_cyc = 0;
    @(negedge clk);
    cmd_phy_addr = phy;
    cmd_reg_addr = rega;
    cmd_valid = 1'b1;
    chk("R9 ready before accept", {31'd0, cmd_ready}, 32'd1);
    @(negedge clk);
    acc = cyc;
    cmd_valid = 1'b0;
    chk("R9 ready low while busy", {31'd0, cmd_ready}, 32'd0);
    for (int r = 0; r < 64; r++) begin
      @(posedge mdc);
      @(negedge clk);
      if (r == 0) begin
        if (cyc != acc + H) rise_bad++;
      end else if (cyc != rise_cyc + 2 * H) begin
        rise_bad++;
      end
      rise_cyc = cyc;
      if (r < 46) begin
        hdr_got[45 - r] = mdio_o;
        if (!mdio_oe) oe_bad = 1'b1;
      end else if (mdio_oe) begin
        oe_bad = 1'b1;
      end
      if (r + 1 == 47) phy_drv = ta_val;
      else if (r + 1 >= 48 && r + 1 < 64) phy_drv = dat[15 - (r + 1 - 48)];
      else phy_drv = 1'b1;
    end
    chk("R1 header bits", {18'd0, hdr_got[45:32]}, {18'd0, hdr_exp[45:32]});
    chk("R1 preamble bits", hdr_got[31:0], hdr_exp[31:0]);
    chk("R2 output enable pattern", {31'd0, oe_bad}, 32'd0);
    chk("R3 mdc rise timing", rise_bad, 0);
    waited = 0;
    while (!rsp_valid && waited < 4 * LAT) begin
      if (clr_at_end && cyc == acc + LAT - 1) begin
        host_we = 1'b1;
        host_wdata = {exp_en, 1'b1};
      end
      @(negedge clk);
      host_we = 1'b0;
      waited++;
    end
    chk("R5 strobe latency", cyc - acc, LAT);
    chk("R4 read data", {16'd0, rsp_data}, {16'd0, dat});
    chk("R6 rsp_err", {31'd0, rsp_err}, {31'd0, ta_val});
    if (ta_val) exp_err = 1'b1;
    else if (clr_at_end) exp_err = 1'b0;
    chk("R6 R8 status after frame", {31'd0, rd_err}, {31'd0, exp_err});
    chk("R7 irq after frame", {31'd0, irq}, {31'd0, exp_err & exp_en});
    @(negedge clk);
    chk("R5 strobe one cycle", {31'd0, rsp_valid}, 32'd0);
    chk("R3 mdc low after frame", {31'd0, mdc}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 rd_err", {31'd0, rd_err}, 32'd0);
    chk("R10 cmd_ready", {31'd0, cmd_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset outputs", {26'd0, rd_err, rd_err_en, irq, rsp_valid, mdc, mdio_oe}, 32'd0);
    chk("R10 ready after reset", {31'd0, cmd_ready}, 32'd1);

    // Sweep: addresses, data patterns, turnaround levels, enable settings.
    for (int i = 0; i < 12; i++) begin
      logic [15:0] d;
      bit ta;
      d = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF : 16'(16'hA5C3 ^ (i * 16'h1357));
      ta = (i % 3 == 1);
      if (i == 4) host_wr(1'b0, 1'b1);
      if (i == 8) host_wr(1'b1, 1'b0);
      run_frame(5'(i * 7), 5'(31 - i * 3), d, ta, 1'b0);
      if (exp_err) begin
        host_wr(1'b0, exp_en);
        chk("R8 write 0 keeps status", {31'd0, rd_err}, 32'd1);
        chk("R7 irq with status held", {31'd0, irq}, {31'd0, exp_en});
        host_wr(1'b1, exp_en);
        chk("R8 write 1 clears status", {31'd0, rd_err}, 32'd0);
        chk("R7 irq after clear", {31'd0, irq}, 32'd0);
      end
    end

    // Set and clear on the same edge: set wins.
    host_wr(1'b0, 1'b1);
    chk("R8 enable written", {31'd0, rd_err_en}, 32'd1);
    run_frame(5'h1F, 5'h00, 16'h8001, 1'b1, 1'b1);
    // Clear on the completion edge of a clean frame: clear takes effect.
    run_frame(5'h00, 5'h1F, 16'h7FFE, 1'b0, 1'b1);
    chk("R8 status cleared", {31'd0, rd_err}, 32'd0);
    host_wr(1'b0, 1'b0);
    chk("R8 enable cleared", {31'd0, rd_err_en}, 32'd0);
    run_frame(5'h15, 5'h0A, 16'h1234, 1'b1, 1'b0);
    chk("R7 irq masked", {31'd0, irq}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule